// File: doc/BRIEF.md
# Audio Serial Clock Divider

This block derives a serial-audio bit clock from a faster parent clock. The parent clock is presented as a one-cycle tick on `par_ce` in the system clock domain. A single 32-bit control word sets the behaviour. Its upper half holds an unsigned integer divide ratio and its two lowest bits are enables. The output `aud_clk` is a level that the audio logic samples.

When the ratio is 0 or 1, the block runs in pass-through mode and `aud_clk` follows the parent tick directly. This happens whatever the enable bits hold. A ratio N of 2 or more, with both enable bits set, produces a square wave with one period every N parent ticks. The wave is high for the first floor(N/2) ticks of each period. A ratio of 2 or more with either enable bit clear parks the output low. Software changes the rate by rewriting the word. While the divider runs, a new ratio waits for the current period to finish, so no period is ever cut short.

Top module: `audio_clk_div`

## Requirements
- R1: After reset the control word reads 0 and `aud_clk` equals `par_ce` in the same cycle.
- R2: A write takes effect at the next clock edge. `rd_data` then returns the ratio in bits 31:16 and the enables in bits 1:0. Bits 15:2 always read 0.
- R3: When the stored ratio is 0 or 1, `aud_clk` equals `par_ce` combinationally, for any enable setting.
- R4: With ratio N ≥ 2 and both enables set, `aud_clk` repeats every N parent ticks. It is high for the first floor(N/2) ticks of each period (odd N included) and low for the rest. It changes in the cycle after the tick that moves it.
- R5: With ratio N ≥ 2 and enable bits other than 11, `aud_clk` is held at 0.
- R6: Writing 0 to the whole word stops the divider at once, and from the next cycle `aud_clk` equals `par_ce`.
- R7: While running, a write that keeps ratio ≥ 2 and enables 11 does not disturb the current period. The new ratio is used from the next period boundary on.
- R8: A write that starts the divider from a non-running state restarts the period, and `aud_clk` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word, with unused bits as 0 |
| par_ce | input | 1 | One-cycle tick per parent clock period |
| aud_clk | output | 1 | Divided or passed-through audio clock |

## Verification
The divider is driven with parent ticks every cycle, every second cycle and every third cycle. This shows that periods count ticks and not system cycles. Even and odd ratios are both run, which separates a correct floor(N/2) high time from a rounded-up one. Irregular tick patterns in pass-through mode confirm that the output tracks the input cycle by cycle and is not a delayed copy. A ratio rewrite in mid-period, a zero write while running, and enable settings of 01 and 10 separate deferred loading from immediate loading and the parked state from pass-through.

// File: rtl/adiv_pkg.sv
package adiv_pkg;

  localparam int unsigned ADIV_REG_W = 32;
  localparam int unsigned ADIV_DIV_W = 16;
  localparam int unsigned ADIV_EN_W  = 2;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_PARK = 2'd1,
    MODE_RUN  = 2'd2
  } adiv_mode_e;

endpackage

// File: rtl/adiv_rst_sync.sv
module adiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/adiv_ctl_reg.sv
module adiv_ctl_reg #(
  parameter int unsigned REG_W = 32,
  parameter int unsigned DIV_W = 16,
  parameter int unsigned EN_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_q,
  output logic [EN_W-1:0]  en_q,
  output logic [DIV_W-1:0] div_d,
  output logic [EN_W-1:0]  en_d,
  output logic [REG_W-1:0] rd_data
);

  localparam int unsigned PAD_W = REG_W - DIV_W - EN_W;

  // next-state: write-through view of the word
  always_comb begin
    div_d = div_q;
    en_d  = en_q;
    if (wr_en) begin
      div_d = wr_data[REG_W-1 -: DIV_W];
      en_d  = wr_data[EN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      en_q  <= '0;
    end else if (wr_en) begin
      div_q <= div_d;
      en_q  <= en_d;
    end
  end

  assign rd_data = {div_q, {PAD_W{1'b0}}, en_q};

endmodule

// File: rtl/adiv_counter.sv
module adiv_counter
  import adiv_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned EN_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] div_d,
  input  logic [EN_W-1:0]  en_d,
  input  logic [EN_W-1:0]  en_q,
  input  logic             tick,
  output logic [DIV_W-1:0] act_div,
  output logic [DIV_W-1:0] phase,
  output logic             run,
  output adiv_mode_e       mode
);

  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);
  localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

  logic [DIV_W-1:0] act_q, act_n;
  logic [DIV_W-1:0] ph_q, ph_n;
  logic             run_next;
  logic             load_en;

  assign run      = (&en_q) && (act_q >= MIN_DIV);
  assign run_next = (&en_d) && (div_d >= MIN_DIV);
  assign load_en  = wr_en || (run && tick);

  always_comb begin
    act_n = act_q;
    ph_n  = ph_q;
    if (wr_en && !(run && run_next)) begin
      // leaving, entering or staying out of the running state: load at once
      act_n = div_d;
      ph_n  = '0;
    end else if (run && tick) begin
      if (ph_q == act_q - ONE) begin
        ph_n  = '0;
        act_n = div_d;   // pending ratio takes over at the boundary
      end else begin
        ph_n  = ph_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      ph_q  <= '0;
    end else if (load_en) begin
      act_q <= act_n;
      ph_q  <= ph_n;
    end
  end

  always_comb begin
    if (act_q < MIN_DIV) mode = MODE_PASS;
    else if (run)        mode = MODE_RUN;
    else                 mode = MODE_PARK;
  end

  assign act_div = act_q;
  assign phase   = ph_q;

endmodule

// File: rtl/adiv_out.sv
module adiv_out
  import adiv_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  adiv_mode_e       mode,
  input  logic [DIV_W-1:0] act_div,
  input  logic [DIV_W-1:0] phase,
  input  logic             tick,
  output logic             clk_out
);

  logic [DIV_W-1:0] high_len;

  assign high_len = act_div >> 1;

  always_comb begin
    case (mode)
      MODE_PASS: clk_out = tick;
      MODE_RUN:  clk_out = (phase < high_len);
      default:   clk_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div
  import adiv_pkg::*;
#(
  parameter int unsigned REG_W = ADIV_REG_W,
  parameter int unsigned DIV_W = ADIV_DIV_W,
  parameter int unsigned EN_W  = ADIV_EN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             par_ce,
  output logic             aud_clk
);

  logic             rst_s;
  logic [DIV_W-1:0] div_q, div_d, act_div, phase;
  logic [EN_W-1:0]  en_q, en_d;
  logic             run_w;
  adiv_mode_e       mode;

  adiv_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s)
  );

  adiv_ctl_reg #(.REG_W(REG_W), .DIV_W(DIV_W), .EN_W(EN_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .div_q   (div_q),
    .en_q    (en_q),
    .div_d   (div_d),
    .en_d    (en_d),
    .rd_data (rd_data)
  );

  adiv_counter #(.DIV_W(DIV_W), .EN_W(EN_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (wr_en),
    .div_d   (div_d),
    .en_d    (en_d),
    .en_q    (en_q),
    .tick    (par_ce),
    .act_div (act_div),
    .phase   (phase),
    .run     (run_w),
    .mode    (mode)
  );

  adiv_out #(.DIV_W(DIV_W)) u_out (
    .mode    (mode),
    .act_div (act_div),
    .phase   (phase),
    .tick    (par_ce),
    .clk_out (aud_clk)
  );

  logic unused_div_q;
  assign unused_div_q = ^div_q;

endmodule

// File: rtl/adiv_checker.sv
module adiv_checker #(
  parameter int unsigned REG_W = 32,
  parameter int unsigned DIV_W = 16,
  parameter int unsigned EN_W  = 2
) (
  input logic             clk,
  input logic             srst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             par_ce,
  input logic             aud_clk,
  input logic             run
);

  localparam int unsigned PAD_W = REG_W - DIV_W - EN_W;

  logic [DIV_W-1:0] rd_div, wr_div;
  logic [EN_W-1:0]  rd_en, wr_en_bits;

  assign rd_div     = rd_data[REG_W-1 -: DIV_W];
  assign rd_en      = rd_data[EN_W-1:0];
  assign wr_div     = wr_data[REG_W-1 -: DIV_W];
  assign wr_en_bits = wr_data[EN_W-1:0];

  p_echo_r2: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en |=> (rd_div == $past(wr_div)) && (rd_en == $past(wr_en_bits)) &&
              (rd_data[EN_W +: PAD_W] == '0));

  p_pass_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_div < DIV_W'(2)) |-> (aud_clk == par_ce));

  p_park_low_r5: assert property (@(posedge clk) disable iff (!srst_n)
    ((rd_div >= DIV_W'(2)) && !(&rd_en)) |-> !aud_clk);

  p_zero_stop_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && (wr_data == '0)) |=> (aud_clk == par_ce));

  p_start_high_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && !run && (wr_div >= DIV_W'(2)) && (&wr_en_bits)) |=> aud_clk);

endmodule

bind audio_clk_div adiv_checker #(.REG_W(REG_W), .DIV_W(DIV_W), .EN_W(EN_W)) u_chk (
  .clk     (clk),
  .srst_n  (rst_s),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .par_ce  (par_ce),
  .aud_clk (aud_clk),
  .run     (run_w)
);

// File: tb/test_audio_clk_div.sv
module test_audio_clk_div;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        par_ce = 1'b0;
  logic [31:0] rd_data;
  logic        aud_clk;

  audio_clk_div i_audio_clk_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .par_ce  (par_ce),
    .aud_clk (aud_clk)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int    exp;   // 0/1 expected, 2 = not compared
    string tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state, from the requirements: 0 pass, 1 park, 2 run
  int m_mode = 0, m_cnt = 0, m_n = 0, m_pend = 0;

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.exp != 2) begin
        n_cmp++;
        if (aud_clk !== it.exp[0]) begin
          n_bad++;
          $display("FAIL %s: aud_clk actual %0b expected %0d at %0t", it.tag, aud_clk, it.exp, $time);
        end
      end
    end
  end

  function automatic int mexp(bit ce);
    if (m_mode == 0) return int'(ce);
    if (m_mode == 1) return 0;
    return (m_cnt < m_n / 2) ? 1 : 0;
  endfunction

  task automatic cyc(bit ce, bit we, logic [31:0] wd, int exp, string tag);
    @(posedge clk);
    #1;
    par_ce  = ce;
    wr_en   = we;
    wr_data = wd;
    q.push_back('{exp, tag});
  endtask

  task automatic step(bit ce, string tag);
    cyc(ce, 1'b0, 32'h0, mexp(ce), tag);
    if (m_mode == 2 && ce) begin
      if (m_cnt == m_n - 1) begin
        m_cnt = 0;
        m_n   = m_pend;
      end else begin
        m_cnt++;
      end
    end
  endtask

  task automatic wr(logic [31:0] d, string tag);
    int  dv;
    bit  nrun;
    cyc(1'b0, 1'b1, d, mexp(1'b0), tag);
    dv   = int'(d[31:16]);
    nrun = (d[1:0] == 2'b11) && (dv >= 2);
    if (m_mode == 2 && nrun) begin
      m_pend = dv;                       // R7: deferred
    end else begin
      m_mode = (dv < 2) ? 0 : (nrun ? 2 : 1);
      m_n    = dv;
      m_pend = dv;
      m_cnt  = 0;
    end
  endtask

  task automatic run(int count, int gap, string tag);
    for (int i = 0; i < count; i++) step((i % gap) == gap - 1, tag);
  endtask

  task automatic pat(logic [15:0] bits, string tag);
    for (int i = 0; i < 16; i++) step(bits[i], tag);
  endtask

  task automatic chk_rd(logic [31:0] exp, string tag);
    @(negedge clk);
    #1;
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data actual %08h expected %08h", tag, rd_data, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    summary();
  end

  initial begin
    // R1: reset state, pass-through while and after reset
    for (int i = 0; i < 4; i++) step(i[0], "R1");
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    pat(16'b1011_0010_1100_0110, "R1");
    chk_rd(32'h0000_0000, "R1");

    // R3: ratio 1 with enables set is still pass-through
    wr({16'd1, 14'd0, 2'b11}, "R3");
    step(1'b1, "R3");
    chk_rd(32'h0001_0003, "R2");
    pat(16'b0110_1001_1100_1010, "R3");
    wr({16'd1, 14'd0, 2'b00}, "R3");
    pat(16'b1000_1110_0101_0011, "R3");

    // R5: parked low with partial enables
    wr({16'd6, 14'd0, 2'b01}, "R5");
    run(14, 1, "R5");
    chk_rd(32'h0006_0001, "R2");
    wr({16'd6, 14'd0, 2'b10}, "R5");
    run(10, 2, "R5");
    chk_rd(32'h0006_0002, "R2");

    // R8 then R4: start and run even ratio, tick every cycle
    wr({16'd6, 14'd0, 2'b11}, "R8");
    run(24, 1, "R4");

    // R6: zero write stops at once
    wr(32'h0, "R6");
    pat(16'b1101_0011_0110_0101, "R6");

    // R4: odd ratio, tick every third cycle
    wr({16'd5, 14'd0, 2'b11}, "R8");
    run(40, 3, "R4");

    // R7: mid-period ratio change
    run(4, 2, "R7");
    wr({16'd8, 14'd0, 2'b11}, "R7");
    run(60, 2, "R7");

    // R2: unused bits read back 0 while ratio is pending
    wr(32'hABCD_FFFF, "R2");
    step(1'b1, "R2");
    chk_rd(32'hABCD_0003, "R2");
    run(8, 1, "R7");

    wr(32'h0, "R6");
    pat(16'b0011_1010_0110_1101, "R6");

    repeat (3) @(posedge clk);
    summary();
  end

endmodule